// File: doc/BRIEF.md
# Command and Completion Mailbox Engine

This block moves work between a host and an adapter through a shared mailbox RAM. The RAM holds a ring of outgoing slots that the host fills with commands, and a ring of incoming slots that the engine fills with completion reports. Each slot is one 32-bit word: an 8-bit tag and a 24-bit pointer.

The engine walks the outgoing ring one slot at a time. A start command is handed downstream on a valid/ready port as a 32-bit address. An abort is resolved against the table of starts still in flight. Any unknown tag is rejected. Every slot the engine consumes is written back to free. Completions arrive on a second valid/ready port with a pointer and a host result code. They are turned into incoming entries, along with the outcome of each abort or rejected command. Entries are posted only into a free incoming slot.

Two sticky interrupt flags report that an outgoing slot was emptied and that an incoming slot was filled. The engine issues at most one memory access per clock on a single request port. Read data returns one cycle after the request.

Top module: `mbx_engine`

## Requirements
- R1: Word layout: outgoing slot i lives at word i and incoming slot i at word NSLOT+i. The tag is in bits 31:24 and the pointer in bits 23:0, with the pointer's most significant byte in bits 23:16.
- R2: An outgoing tag 0x01 (start) causes the slot to be rewritten to 0x00000000. The pointer is presented on the start port as a 32-bit address whose top byte is zero. Valid and address hold steady until ready is seen.
- R3: The outgoing ring is scanned in rising slot order with wrap-around, continuing after the last slot taken. Starts waiting in successive slots are forwarded in slot order.
- R4: A completion request with result code 0x00 posts status 0x01 (success). Any non-zero result code posts status 0x04 (error). The posted pointer is the low 24 bits of the completion address.
- R5: An outgoing tag 0x02 (abort) whose pointer equals an outstanding start posts status 0x02 (aborted) and retires that start. A repeated abort of the same pointer then finds nothing.
- R6: An abort whose pointer matches no outstanding start posts status 0x03 (not found).
- R7: An outgoing tag other than 0x00, 0x01 or 0x02 is freed and handled as host status 0x15 (bad command). That host status posts status 0x04 with the slot's pointer.
- R8: Incoming entries go to the next incoming slot in ring order, and only when that slot reads 0x00. Otherwise posting stalls, the slot is left untouched and no further completion is accepted until the host frees it.
- R9: Interrupt flag bit 1 is set when an outgoing slot is freed and bit 0 when an incoming slot is written. Bit 7 is their OR. A pulse on irq_clr clears both, unless a new event occurs in the same cycle.
- R10: At most ACT_DEPTH starts may be outstanding. A start met while the table is full is left in its slot untouched and is taken once a completion retires an entry.
- R11: Slots holding 0x00 are passed over: with no commands and no completions, nothing appears on the start port and no incoming slot or interrupt flag changes.
- R12: The engine writes only 0x00000000 into outgoing slots, and only status values 0x01 to 0x04 into incoming slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_req | output | 1 | Mailbox RAM access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W (3) | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after a read request |
| start_valid | output | 1 | Start address offered downstream |
| start_ready | input | 1 | Downstream takes the start |
| start_addr | output | ADDR_OUT_W (32) | Start pointer, zero-extended |
| done_valid | input | 1 | Completion offered |
| done_ready | output | 1 | Engine takes the completion |
| done_addr | input | ADDR_OUT_W (32) | Completed pointer |
| done_code | input | 8 | Host result code, 0x00 = good |
| irq_clr | input | 1 | Clear both interrupt flags |
| irq_flags | output | 8 | Bit 7 any, bit 1 outgoing emptied, bit 0 incoming filled |

## Verification
The hardest state to reach is a posted entry held back by a full incoming ring. Reaching it takes one completion per incoming slot, with the host leaving every slot occupied, and then one more completion. The stimulus does exactly that. It then watches the blocked slot stay unchanged and done_ready stay low, frees one slot, and sees the held entry land there. The table-full case is reached the same way: the host issues starts until the table is full, then adds one more, and the extra start must stay untouched in its slot until a completion retires an entry.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   localparam int TAG_W = 8;

   localparam logic [TAG_W-1:0] OUT_FREE  = 8'h00;
   localparam logic [TAG_W-1:0] OUT_START = 8'h01;
   localparam logic [TAG_W-1:0] OUT_ABORT = 8'h02;

   localparam logic [TAG_W-1:0] IN_FREE     = 8'h00;
   localparam logic [TAG_W-1:0] IN_SUCCESS  = 8'h01;
   localparam logic [TAG_W-1:0] IN_ABORTED  = 8'h02;
   localparam logic [TAG_W-1:0] IN_NOTFOUND = 8'h03;
   localparam logic [TAG_W-1:0] IN_ERROR    = 8'h04;

   localparam logic [7:0] HSTAT_GOOD    = 8'h00;
   localparam logic [7:0] HSTAT_BAD_CMD = 8'h15;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SCAN_EV,
      ST_FWD,
      ST_POST_EV
   } eng_state_t;

   function automatic logic [TAG_W-1:0] hstat_to_status(input logic [7:0] hs);
      return (hs == HSTAT_GOOD) ? IN_SUCCESS : IN_ERROR;
   endfunction
endpackage

// File: rtl/mbx_ring.sv
module mbx_ring #(
   parameter int N = 4,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   output logic [IW-1:0] idx
);
   logic [IW-1:0] nxt;

   generate
      if ((N & (N - 1)) == 0) begin : g_pow2
         assign nxt = idx + IW'(1);
      end else begin : g_mod
         assign nxt = (idx == IW'(N - 1)) ? '0 : idx + IW'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)   idx <= '0;
      else if (adv) idx <= nxt;
   end
endmodule

// File: rtl/mbx_active_table.sv
module mbx_active_table #(
   parameter int DEPTH = 4,
   parameter int PTR_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ins_en,
   input  logic [PTR_W-1:0] ins_ptr,
   input  logic [PTR_W-1:0] lk_ptr,
   input  logic             del_en,
   output logic             hit,
   output logic             full
);
   logic [DEPTH-1:0] vld;
   logic [DEPTH-1:0] match;
   logic [DEPTH-1:0] free_oh;
   logic [PTR_W-1:0] ptrs [DEPTH];

   genvar g;
   generate
      for (g = 0; g < DEPTH; g++) begin : g_cmp
         assign match[g] = vld[g] && (ptrs[g] == lk_ptr);
      end
   endgenerate

   always_comb begin
      logic found;
      found   = 1'b0;
      free_oh = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (!vld[i] && !found) begin
            free_oh[i] = 1'b1;
            found      = 1'b1;
         end
      end
   end

   assign hit  = |match;
   assign full = &vld;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld <= '0;
      end else begin
         vld <= (vld & ~(del_en ? match : '0)) | (ins_en ? free_oh : '0);
      end
   end

   generate
      for (g = 0; g < DEPTH; g++) begin : g_store
         always_ff @(posedge clk) begin
            if (ins_en && free_oh[g]) ptrs[g] <= ins_ptr;
         end
      end
   endgenerate
endmodule

// File: rtl/mbx_engine.sv
module mbx_engine
   import mbx_pkg::*;
#(
   parameter int NSLOT      = 4,
   parameter int PTR_W      = 24,
   parameter int ACT_DEPTH  = 4,
   parameter int ADDR_OUT_W = 32,
   localparam int WORD_W    = TAG_W + PTR_W,
   localparam int ADDR_W    = $clog2(2 * NSLOT)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   output logic                  mem_req,
   output logic                  mem_we,
   output logic [ADDR_W-1:0]     mem_addr,
   output logic [WORD_W-1:0]     mem_wdata,
   input  logic [WORD_W-1:0]     mem_rdata,
   output logic                  start_valid,
   input  logic                  start_ready,
   output logic [ADDR_OUT_W-1:0] start_addr,
   input  logic                  done_valid,
   output logic                  done_ready,
   input  logic [ADDR_OUT_W-1:0] done_addr,
   input  logic [7:0]            done_code,
   input  logic                  irq_clr,
   output logic [7:0]            irq_flags
);
   localparam int IDX_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;

   generate
      if (NSLOT < 2)             begin : g_bad_nslot $error("NSLOT must be at least 2"); end
      if (ACT_DEPTH < 1)         begin : g_bad_depth $error("ACT_DEPTH must be at least 1"); end
      if (ADDR_OUT_W < PTR_W)    begin : g_bad_aw    $error("ADDR_OUT_W below PTR_W"); end
      if (WORD_W != 32)          begin : g_bad_word  $error("mailbox word must be 32 bits"); end
   endgenerate

   eng_state_t state, nxt_state;

   logic [IDX_W-1:0] scan_idx, post_idx;
   logic             scan_adv, post_adv;
   logic             ins_en, del_en, tbl_hit, tbl_full;
   logic [PTR_W-1:0] lk_ptr;

   logic             pq_valid;
   logic [TAG_W-1:0] pq_status;
   logic [PTR_W-1:0] pq_ptr;
   logic             pq_load, pq_clear;
   logic [TAG_W-1:0] pq_nst;
   logic [PTR_W-1:0] pq_nptr;

   logic [PTR_W-1:0] fwd_ptr;
   logic             fwd_load;
   logic             mbo_set, mbi_set;
   logic             mbo_flag, mbi_flag;

   logic [TAG_W-1:0] rd_tag;
   logic [PTR_W-1:0] rd_ptr;
   assign rd_tag = mem_rdata[WORD_W-1 -: TAG_W];
   assign rd_ptr = mem_rdata[PTR_W-1:0];

   mbx_ring #(.N(NSLOT)) u_scan (
      .clk(clk), .rst_n(rst_n), .adv(scan_adv), .idx(scan_idx)
   );

   mbx_ring #(.N(NSLOT)) u_post (
      .clk(clk), .rst_n(rst_n), .adv(post_adv), .idx(post_idx)
   );

   mbx_active_table #(.DEPTH(ACT_DEPTH), .PTR_W(PTR_W)) u_tbl (
      .clk(clk), .rst_n(rst_n),
      .ins_en(ins_en), .ins_ptr(fwd_ptr),
      .lk_ptr(lk_ptr), .del_en(del_en),
      .hit(tbl_hit), .full(tbl_full)
   );

   assign done_ready = (state == ST_IDLE) && !pq_valid;

   always_comb begin
      nxt_state  = state;
      mem_req    = 1'b0;
      mem_we     = 1'b0;
      mem_addr   = '0;
      mem_wdata  = '0;
      scan_adv   = 1'b0;
      post_adv   = 1'b0;
      ins_en     = 1'b0;
      del_en     = 1'b0;
      lk_ptr     = done_addr[PTR_W-1:0];
      start_valid = 1'b0;
      mbo_set    = 1'b0;
      mbi_set    = 1'b0;
      pq_load    = 1'b0;
      pq_clear   = 1'b0;
      pq_nst     = IN_FREE;
      pq_nptr    = '0;
      fwd_load   = 1'b0;

      unique case (state)
         ST_IDLE: begin
            if (pq_valid) begin
               mem_req   = 1'b1;
               mem_addr  = ADDR_W'(NSLOT) + ADDR_W'(post_idx);
               nxt_state = ST_POST_EV;
            end else if (done_valid) begin
               del_en  = tbl_hit;
               pq_load = 1'b1;
               pq_nst  = hstat_to_status(done_code);
               pq_nptr = done_addr[PTR_W-1:0];
            end else begin
               mem_req   = 1'b1;
               mem_addr  = ADDR_W'(scan_idx);
               nxt_state = ST_SCAN_EV;
            end
         end

         ST_SCAN_EV: begin
            lk_ptr    = rd_ptr;
            nxt_state = ST_IDLE;
            scan_adv  = 1'b1;
            if (rd_tag == OUT_FREE) begin
               // nothing to take
            end else if (rd_tag == OUT_START) begin
               if (!tbl_full) begin
                  mem_req   = 1'b1;
                  mem_we    = 1'b1;
                  mem_addr  = ADDR_W'(scan_idx);
                  mbo_set   = 1'b1;
                  fwd_load  = 1'b1;
                  nxt_state = ST_FWD;
               end
            end else if (rd_tag == OUT_ABORT) begin
               mem_req  = 1'b1;
               mem_we   = 1'b1;
               mem_addr = ADDR_W'(scan_idx);
               mbo_set  = 1'b1;
               del_en   = tbl_hit;
               pq_load  = 1'b1;
               pq_nst   = tbl_hit ? IN_ABORTED : IN_NOTFOUND;
               pq_nptr  = rd_ptr;
            end else begin
               mem_req  = 1'b1;
               mem_we   = 1'b1;
               mem_addr = ADDR_W'(scan_idx);
               mbo_set  = 1'b1;
               pq_load  = 1'b1;
               pq_nst   = hstat_to_status(HSTAT_BAD_CMD);
               pq_nptr  = rd_ptr;
            end
         end

         ST_FWD: begin
            start_valid = 1'b1;
            if (start_ready) begin
               ins_en    = 1'b1;
               nxt_state = ST_IDLE;
            end
         end

         ST_POST_EV: begin
            nxt_state = ST_IDLE;
            if (rd_tag == IN_FREE) begin
               mem_req   = 1'b1;
               mem_we    = 1'b1;
               mem_addr  = ADDR_W'(NSLOT) + ADDR_W'(post_idx);
               mem_wdata = {pq_status, pq_ptr};
               mbi_set   = 1'b1;
               post_adv  = 1'b1;
               pq_clear  = 1'b1;
            end
         end

         default: nxt_state = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         pq_valid <= 1'b0;
         mbo_flag <= 1'b0;
         mbi_flag <= 1'b0;
      end else begin
         state <= nxt_state;
         if (pq_load)       pq_valid <= 1'b1;
         else if (pq_clear) pq_valid <= 1'b0;
         if (mbo_set)       mbo_flag <= 1'b1;
         else if (irq_clr)  mbo_flag <= 1'b0;
         if (mbi_set)       mbi_flag <= 1'b1;
         else if (irq_clr)  mbi_flag <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (pq_load) begin
         pq_status <= pq_nst;
         pq_ptr    <= pq_nptr;
      end
      if (fwd_load) fwd_ptr <= rd_ptr;
   end

   assign start_addr = ADDR_OUT_W'(fwd_ptr);
   assign irq_flags  = {mbo_flag | mbi_flag, 5'b0, mbo_flag, mbi_flag};
endmodule

// File: rtl/mbx_engine_chk.sv
module mbx_engine_chk #(
   parameter int NSLOT      = 4,
   parameter int PTR_W      = 24,
   parameter int ADDR_OUT_W = 32,
   parameter int WORD_W     = 32,
   parameter int ADDR_W     = 3
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  mem_req,
   input logic                  mem_we,
   input logic [ADDR_W-1:0]     mem_addr,
   input logic [WORD_W-1:0]     mem_wdata,
   input logic                  start_valid,
   input logic                  start_ready,
   input logic [ADDR_OUT_W-1:0] start_addr,
   input logic                  irq_clr,
   input logic [7:0]            irq_flags
);
   logic wr_out, wr_in;
   logic [7:0] wr_tag;
   assign wr_out = mem_req && mem_we && (int'(mem_addr) < NSLOT);
   assign wr_in  = mem_req && mem_we && (int'(mem_addr) >= NSLOT);
   assign wr_tag = mem_wdata[WORD_W-1 -: 8];

   a_r2_start_hold: assert property (@(posedge clk) disable iff (!rst_n)
      start_valid && !start_ready |=> start_valid && $stable(start_addr));

   a_r2_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
      start_valid |-> (start_addr >> PTR_W) == '0);

   a_r12_out_free: assert property (@(posedge clk) disable iff (!rst_n)
      wr_out |-> mem_wdata == '0);

   a_r12_in_status: assert property (@(posedge clk) disable iff (!rst_n)
      wr_in |-> (wr_tag >= 8'h01 && wr_tag <= 8'h04));

   a_r9_mbi_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_flags[0]) |-> $past(wr_in));

   a_r9_mbo_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_flags[1]) |-> $past(wr_out));

   a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
      irq_clr && !(mem_req && mem_we) |=> irq_flags == 8'h00);
endmodule

bind mbx_engine mbx_engine_chk #(
   .NSLOT(NSLOT), .PTR_W(PTR_W), .ADDR_OUT_W(ADDR_OUT_W),
   .WORD_W(WORD_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
   .mem_addr(mem_addr), .mem_wdata(mem_wdata),
   .start_valid(start_valid), .start_ready(start_ready),
   .start_addr(start_addr), .irq_clr(irq_clr), .irq_flags(irq_flags)
);

// File: tb/mbx_engine_test.sv
module mbx_engine_test;
   localparam int NSLOT = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mem_req, mem_we;
   logic [2:0]  mem_addr;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata = '0;
   logic        start_valid;
   logic        start_ready = 1'b1;
   logic [31:0] start_addr;
   logic        done_valid = 1'b0;
   logic        done_ready;
   logic [31:0] done_addr = '0;
   logic [7:0]  done_code = '0;
   logic        irq_clr = 1'b0;
   logic [7:0]  irq_flags;

   logic [31:0] mem [2*NSLOT];
   logic [31:0] acc_q [64];
   int          acc_n = 0;
   int          n_chk = 0;
   int          n_fail = 0;
   int          out_next = 0;
   int          in_next = 0;

   always #4 clk = ~clk;

   mbx_engine uut (
      .clk(clk), .rst_n(rst_n),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .start_valid(start_valid), .start_ready(start_ready), .start_addr(start_addr),
      .done_valid(done_valid), .done_ready(done_ready),
      .done_addr(done_addr), .done_code(done_code),
      .irq_clr(irq_clr), .irq_flags(irq_flags)
   );

   always @(posedge clk) begin
      if (mem_req) begin
         if (mem_we) mem[mem_addr] <= mem_wdata;
         else        mem_rdata <= mem[mem_addr];
      end
   end

   always @(negedge clk) begin
      if (rst_n && start_valid && start_ready) begin
         acc_q[acc_n % 64] = start_addr;
         acc_n++;
      end
   end

   task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", r, act, exp);
      end
   endtask

   task automatic host_out(input logic [7:0] tag, input logic [23:0] ptr);
      mem[out_next] = {tag, ptr};
      out_next = (out_next + 1) % NSLOT;
   endtask

   task automatic wait_acc(input int n, input string r);
      int t;
      t = 0;
      while (acc_n < n && t < 400) begin @(negedge clk); t++; end
      chk(r, 32'(acc_n), 32'(n));
   endtask

   task automatic send_done(input logic [31:0] a, input logic [7:0] c, input string r);
      int t;
      t = 0;
      done_valid = 1'b1; done_addr = a; done_code = c;
      while (!done_ready && t < 500) begin @(negedge clk); t++; end
      if (done_ready) @(negedge clk);
      else chk(r, 32'(done_ready), 32'd1);
      done_valid = 1'b0;
   endtask

   task automatic expect_post(input logic [7:0] st, input logic [23:0] ptr,
                              input bit keep, input string r);
      int t;
      t = 0;
      while (mem[NSLOT + in_next][31:24] == 8'h00 && t < 400) begin @(negedge clk); t++; end
      chk(r, mem[NSLOT + in_next], {st, ptr});
      if (!keep) mem[NSLOT + in_next] = '0;
      in_next = (in_next + 1) % NSLOT;
   endtask

   task automatic t_reset;
      repeat (2) @(negedge clk);
      chk("R9 reset flags", 32'(irq_flags), 32'h0);
      chk("R2 reset start_valid", 32'(start_valid), 32'h0);
      repeat (40) @(negedge clk);
      chk("R11 idle no starts", 32'(acc_n), 32'h0);
      chk("R11 idle no flags", 32'(irq_flags), 32'h0);
      for (int i = 0; i < NSLOT; i++) chk("R11 idle in slot", mem[NSLOT + i], 32'h0);
   endtask

   task automatic t_start_done;
      int s;
      s = out_next;
      host_out(8'h01, 24'h123456);
      wait_acc(1, "R2 start taken");
      chk("R2 start address", acc_q[0], 32'h0012_3456);
      chk("R2 slot freed", mem[s], 32'h0);
      chk("R9 out-empty flag", 32'(irq_flags[1]), 32'h1);
      send_done(32'h0012_3456, 8'h00, "R4 accept");
      expect_post(8'h01, 24'h123456, 1'b0, "R1 R4 success entry");
      chk("R9 in-full and any", 32'({irq_flags[7], irq_flags[0]}), 32'h3);
      send_done(32'h00AB_CDEF, 8'h12, "R4 accept err");
      expect_post(8'h04, 24'hABCDEF, 1'b0, "R4 error entry");
   endtask

   task automatic t_order;
      int b;
      start_ready = 1'b0;
      b = acc_n;
      host_out(8'h01, 24'h111111);
      for (int t = 0; t < 200 && !start_valid; t++) @(negedge clk);
      host_out(8'h01, 24'h222222);
      host_out(8'h01, 24'h333333);
      repeat (10) @(negedge clk);
      chk("R2 hold valid", 32'(start_valid), 32'h1);
      chk("R2 hold address", start_addr, 32'h0011_1111);
      start_ready = 1'b1;
      wait_acc(b + 3, "R3 three starts");
      chk("R3 order first", acc_q[b % 64], 32'h0011_1111);
      chk("R3 order second", acc_q[(b + 1) % 64], 32'h0022_2222);
      chk("R3 order third", acc_q[(b + 2) % 64], 32'h0033_3333);
      send_done(32'h0011_1111, 8'h00, "R4");
      expect_post(8'h01, 24'h111111, 1'b0, "R4 post a");
      send_done(32'h0022_2222, 8'h00, "R4");
      expect_post(8'h01, 24'h222222, 1'b0, "R4 post b");
      send_done(32'h0033_3333, 8'h00, "R4");
      expect_post(8'h01, 24'h333333, 1'b0, "R4 post c");
   endtask

   task automatic t_abort;
      int b, s;
      b = acc_n;
      host_out(8'h01, 24'h0A0B0C);
      wait_acc(b + 1, "R5 start before abort");
      host_out(8'h02, 24'h0A0B0C);
      expect_post(8'h02, 24'h0A0B0C, 1'b0, "R5 aborted entry");
      host_out(8'h02, 24'h0A0B0C);
      expect_post(8'h03, 24'h0A0B0C, 1'b0, "R5 retired after abort");
      host_out(8'h02, 24'h777777);
      expect_post(8'h03, 24'h777777, 1'b0, "R6 not found entry");
      s = out_next;
      host_out(8'h07, 24'h456789);
      expect_post(8'h04, 24'h456789, 1'b0, "R7 bad command entry");
      chk("R7 R12 bad slot freed", mem[s], 32'h0);
   endtask

   task automatic t_full;
      int b, s;
      b = acc_n;
      for (int i = 0; i < 4; i++) host_out(8'h01, 24'h500000 + 24'(i));
      wait_acc(b + 4, "R10 four starts");
      s = out_next;
      host_out(8'h01, 24'h5000AA);
      repeat (40) @(negedge clk);
      chk("R10 fifth stays", mem[s], 32'h015000AA);
      chk("R10 nothing forwarded", 32'(acc_n), 32'(b + 4));
      send_done(32'h0050_0000, 8'h00, "R10");
      expect_post(8'h01, 24'h500000, 1'b0, "R10 retire one");
      wait_acc(b + 5, "R10 fifth taken");
      chk("R10 fifth address", acc_q[(b + 4) % 64], 32'h0050_00AA);
      for (int i = 1; i < 4; i++) begin
         send_done(32'h0050_0000 + 32'(i), 8'h00, "R10");
         expect_post(8'h01, 24'h500000 + 24'(i), 1'b0, "R10 drain");
      end
      send_done(32'h0050_00AA, 8'h00, "R10");
      expect_post(8'h01, 24'h5000AA, 1'b0, "R10 drain last");
   endtask

   task automatic t_stall;
      int base;
      base = in_next;
      for (int i = 0; i < 4; i++) begin
         send_done(32'h0060_0000 + 32'(i), 8'h00, "R8");
         expect_post(8'h01, 24'h600000 + 24'(i), 1'b1, "R8 fill ring");
      end
      send_done(32'h0060_0004, 8'h00, "R8");
      repeat (40) @(negedge clk);
      chk("R8 blocked slot untouched", mem[NSLOT + base], 32'h01600000);
      chk("R8 no new completion", 32'(done_ready), 32'h0);
      mem[NSLOT + base] = '0;
      in_next = (base + 1) % NSLOT;
      for (int i = 1; i < 5; i++)
         expect_post(8'h01, 24'h600000 + 24'(i), 1'b0, "R8 drain after release");
   endtask

   task automatic t_clear;
      chk("R9 flags before clear", 32'(irq_flags), 32'h83);
      irq_clr = 1'b1;
      @(negedge clk);
      irq_clr = 1'b0;
      @(negedge clk);
      chk("R9 cleared", 32'(irq_flags), 32'h0);
   endtask

   initial begin
      for (int i = 0; i < 2 * NSLOT; i++) mem[i] = '0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_start_done();
      t_order();
      t_abort();
      t_full();
      t_stall();
      t_clear();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(8 * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule